// File: doc/BRIEF.md
# Clock Output Gating Controller

This block sits between the internal clock sources of a multi-output clock generator and its output pins. For every output it decides, cycle by cycle, whether the raw clock passes through, is held low, or (for the complementary CPU clock only) is released to high impedance. The controls are an active-low power-down pin, an active-low CPU-stop pin, a mode strap that turns the shared reference/stop pin into either a clock output or the stop input, and a set of per-output enable bits written by software.

All raw clocks are treated as oversampled signals in the `clk` domain. The power-down and stop pins pass through two-flop synchronizers. Each output has its own gate register, and that register changes only on an edge where its raw clock was sampled low. Because of this, an output is never started or cut part-way through a high phase. The block also resolves the 5-bit frequency-select code, either from the latched strap pins or from a software register, and reports whether that code permits spread-spectrum modulation.

Top module: `clk_gate_ctrl`

## Requirements
- R1: While power-down is in effect, `cpu_c_oe` is 0 and every clock output (`cpu_t`, `cpu_c`, `cpu_cs`, `pci_out`, `ref_out`, `usb_out`, `sio_out`, `sdram_out`) is 0. This is also the state from reset until the synchronized pin reports power-up.
- R2: With `mode_strap`=0, a low `stop_pin_n` drives `cpu_t` and `cpu_cs` to 0 and makes `cpu_c_oe` 0. PCI, reference, USB, SIO and SDRAM outputs are unaffected.
- R3: With `mode_strap`=1, `ref0_oe` is 1, `ref_out[0]` carries the reference clock, and `stop_pin_n` has no effect. With `mode_strap`=0, `ref0_oe` is 0 and `ref_out[0]` is held at 0.
- R4: An output whose enable bit is 0 (`en_pci[i]`, `en_ref[i]`, `en_usb`, `en_sio`) is held at 0. An output whose enable bit is 1 follows its raw clock.
- R5: Every bit of `sdram_out` is a copy of `sdram_in`, except during power-down, when all bits are 0.
- R6: `cpu_cs` is equal to `cpu_t` on every cycle.
- R7: When `sw_sel`=0, `fs_code` = {1, `strap_fs[3:0]`}. When `sw_sel`=1, `fs_code` = `sw_code[4:0]`. Bit 4 is the most significant bit.
- R8: `ss_allow` is 1 exactly when `fs_code[4:2]` = 3'b111, that is, for codes 11100 to 11111.
- R9: A gate register changes only on an edge at which its raw clock was sampled low. A gated output therefore never rises while its raw clock stays high, and is never cut during a high phase.
- R10: A pin change sampled at edge k can alter a gate no earlier than edge k+2. Priority is power-down, then stop, then enable bits.
- R11: `sio_out` gates `usb_raw` when `sio_sel48`=1 and gates `sio24_raw` when `sio_sel48`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrdn_n | input | 1 | Power-down request, active low |
| stop_pin_n | input | 1 | CPU-stop request, active low, honoured only in mode 0 |
| mode_strap | input | 1 | Latched pin role: 0 = stop input, 1 = reference output |
| strap_fs | input | 4 | Latched hardware frequency strap |
| sw_sel | input | 1 | 1 selects the software frequency code |
| sw_code | input | 5 | Software frequency code |
| en_pci | input | 6 | Per-output PCI enables |
| en_ref | input | 2 | Per-output reference enables |
| en_usb | input | 1 | USB clock enable |
| en_sio | input | 1 | SIO clock enable |
| sio_sel48 | input | 1 | SIO clock source select |
| cpu_raw | input | 1 | Raw CPU clock |
| pci_raw | input | 1 | Raw PCI clock |
| ref_raw | input | 1 | Raw reference clock |
| usb_raw | input | 1 | Raw 48 MHz clock |
| sio24_raw | input | 1 | Raw 24 MHz clock |
| sdram_in | input | 1 | Buffered SDRAM clock input |
| cpu_t | output | 1 | True CPU clock |
| cpu_c | output | 1 | Complementary CPU clock data |
| cpu_c_oe | output | 1 | Output enable of the complementary CPU clock |
| cpu_cs | output | 1 | Chipset copy of the true CPU clock |
| pci_out | output | 6 | Gated PCI clocks |
| ref_out | output | 2 | Gated reference clocks |
| ref0_oe | output | 1 | Output enable of the shared reference/stop pin |
| usb_out | output | 1 | Gated USB clock |
| sio_out | output | 1 | Gated SIO clock |
| sdram_out | output | 13 | SDRAM clock copies |
| fs_code | output | 5 | Resolved frequency-select code |
| ss_allow | output | 1 | Spread spectrum permitted for `fs_code` |

## Verification
The bench drives slow raw clocks with long high phases, so that a request arriving mid-phase has to wait. A design that gated on the request alone would produce a short high pulse, and both the cycle reference model and the pulse-shape check would catch it. A design that skipped the synchronizer stages, or added an extra one, would shift the edge at which outputs stop, and the cycle compare would report that shift.

The bench asserts stop while power-down is active, and asserts stop while the pin is configured as a reference output. These catch designs with the wrong priority and designs that ignore the mode strap. Sweeping every software code and every strap value catches a wrong bit order in the code and a wrong spread-spectrum boundary.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;
    localparam int NPCI    = 6;
    localparam int NREF    = 2;
    localparam int NSDRAM  = 13;
    localparam int STRAP_W = 4;
    localparam int CODE_W  = STRAP_W + 1;

    typedef logic [CODE_W-1:0] fcode_t;

    // Gate cell output variants
    typedef enum logic [1:0] {
        GC_TRUE  = 2'd0,
        GC_COMP  = 2'd1,
        GC_LEVEL = 2'd2
    } gc_kind_e;

    // Synchronized control view
    typedef struct packed {
        logic pd_ok;    // 1 = not powered down
        logic stop_ok;  // 1 = CPU clocks may run
    } ctl_t;

    function automatic fcode_t pick_code(input logic sw, input fcode_t swc,
                                         input logic [STRAP_W-1:0] strap);
        return sw ? swc : {1'b1, strap};
    endfunction

    function automatic logic spread_ok(input fcode_t c);
        return c[CODE_W-1 -: 3] == 3'b111;
    endfunction
endpackage

// File: rtl/clkgate_sync.sv
`timescale 1ns/1ps
module clkgate_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic s1;
    logic s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= RST_VAL;
            s2 <= RST_VAL;
        end else begin
            s1 <= d;
            s2 <= s1;
        end
    end

    assign q = s2;
endmodule

// File: rtl/clkgate_fsel.sv
`timescale 1ns/1ps
module clkgate_fsel
    import clkgate_pkg::*;
(
    input  logic               sw_sel,
    input  logic [CODE_W-1:0]  sw_code,
    input  logic [STRAP_W-1:0] strap_fs,
    output logic [CODE_W-1:0]  fs_code,
    output logic               ss_allow
);
    fcode_t code;

    always_comb begin
        code     = pick_code(sw_sel, sw_code, strap_fs);
        fs_code  = code;
        ss_allow = spread_ok(code);
    end
endmodule

// File: rtl/clkgate_cell.sv
`timescale 1ns/1ps
module clkgate_cell
    import clkgate_pkg::*;
#(
    parameter gc_kind_e KIND = GC_TRUE
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic want,
    output logic gated
);
    logic run_q;

    // State moves only while the raw clock is low
    always_ff @(posedge clk) begin
        if (rst)
            run_q <= 1'b0;
        else if (!raw)
            run_q <= want;
    end

    generate
        if (KIND == GC_TRUE) begin : g_true
            assign gated = raw & run_q;

            assert_no_runt_start_R9: assert property (@(posedge clk) disable iff (rst)
                $rose(gated) |-> !$past(raw))
                else $error("gate started inside a high phase");

            assert_no_cut_high_R9: assert property (@(posedge clk) disable iff (rst)
                ($past(gated) && raw && $past(raw)) |-> gated)
                else $error("gate cut a high phase");
        end else if (KIND == GC_COMP) begin : g_comp
            assign gated = ~raw & run_q;
        end else begin : g_level
            assign gated = run_q;
        end
    endgenerate

    assert_run_needs_want_R10: assert property (@(posedge clk) disable iff (rst)
        (run_q && !$past(run_q)) |-> $past(want))
        else $error("gate opened without request");
endmodule

// File: rtl/clk_gate_ctrl.sv
`timescale 1ns/1ps
module clk_gate_ctrl
    import clkgate_pkg::*;
#(
    parameter int N_PCI = NPCI,
    parameter int N_REF = NREF,
    parameter int N_SD  = NSDRAM
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwrdn_n,
    input  logic               stop_pin_n,
    input  logic               mode_strap,
    input  logic [STRAP_W-1:0] strap_fs,
    input  logic               sw_sel,
    input  logic [CODE_W-1:0]  sw_code,
    input  logic [N_PCI-1:0]   en_pci,
    input  logic [N_REF-1:0]   en_ref,
    input  logic               en_usb,
    input  logic               en_sio,
    input  logic               sio_sel48,
    input  logic               cpu_raw,
    input  logic               pci_raw,
    input  logic               ref_raw,
    input  logic               usb_raw,
    input  logic               sio24_raw,
    input  logic               sdram_in,
    output logic               cpu_t,
    output logic               cpu_c,
    output logic               cpu_c_oe,
    output logic               cpu_cs,
    output logic [N_PCI-1:0]   pci_out,
    output logic [N_REF-1:0]   ref_out,
    output logic               ref0_oe,
    output logic               usb_out,
    output logic               sio_out,
    output logic [N_SD-1:0]    sdram_out,
    output logic [CODE_W-1:0]  fs_code,
    output logic               ss_allow
);
    logic pd_s;
    logic stop_s;
    ctl_t ctl;
    logic want_cpu;
    logic sio_src;
    logic sd_gated;

    clkgate_sync #(.RST_VAL(1'b0)) u_sync_pd (
        .clk(clk), .rst(rst), .d(pwrdn_n), .q(pd_s));

    clkgate_sync #(.RST_VAL(1'b1)) u_sync_stop (
        .clk(clk), .rst(rst), .d(stop_pin_n), .q(stop_s));

    always_comb begin
        ctl.pd_ok   = pd_s;
        ctl.stop_ok = mode_strap | stop_s;
        want_cpu    = ctl.pd_ok & ctl.stop_ok;
        sio_src     = sio_sel48 ? usb_raw : sio24_raw;
    end

    assign ref0_oe = mode_strap;

    // CPU group: true, chipset copy, complement data and its enable
    clkgate_cell #(.KIND(GC_TRUE)) u_cpu_t (
        .clk(clk), .rst(rst), .raw(cpu_raw), .want(want_cpu), .gated(cpu_t));
    clkgate_cell #(.KIND(GC_TRUE)) u_cpu_cs (
        .clk(clk), .rst(rst), .raw(cpu_raw), .want(want_cpu), .gated(cpu_cs));
    clkgate_cell #(.KIND(GC_COMP)) u_cpu_c (
        .clk(clk), .rst(rst), .raw(cpu_raw), .want(want_cpu), .gated(cpu_c));
    clkgate_cell #(.KIND(GC_LEVEL)) u_cpu_oe (
        .clk(clk), .rst(rst), .raw(cpu_raw), .want(want_cpu), .gated(cpu_c_oe));

    generate
        for (genvar i = 0; i < N_PCI; i++) begin : g_pci
            clkgate_cell #(.KIND(GC_TRUE)) u_pci (
                .clk(clk), .rst(rst), .raw(pci_raw),
                .want(ctl.pd_ok & en_pci[i]), .gated(pci_out[i]));
        end
        for (genvar i = 0; i < N_REF; i++) begin : g_ref
            if (i == 0) begin : g_shared
                clkgate_cell #(.KIND(GC_TRUE)) u_ref (
                    .clk(clk), .rst(rst), .raw(ref_raw),
                    .want(ctl.pd_ok & en_ref[i] & mode_strap), .gated(ref_out[i]));
            end else begin : g_plain
                clkgate_cell #(.KIND(GC_TRUE)) u_ref (
                    .clk(clk), .rst(rst), .raw(ref_raw),
                    .want(ctl.pd_ok & en_ref[i]), .gated(ref_out[i]));
            end
        end
        for (genvar i = 0; i < N_SD; i++) begin : g_sd
            assign sdram_out[i] = sd_gated;
        end
    endgenerate

    clkgate_cell #(.KIND(GC_TRUE)) u_usb (
        .clk(clk), .rst(rst), .raw(usb_raw), .want(ctl.pd_ok & en_usb), .gated(usb_out));
    clkgate_cell #(.KIND(GC_TRUE)) u_sio (
        .clk(clk), .rst(rst), .raw(sio_src), .want(ctl.pd_ok & en_sio), .gated(sio_out));
    clkgate_cell #(.KIND(GC_TRUE)) u_sd (
        .clk(clk), .rst(rst), .raw(sdram_in), .want(ctl.pd_ok), .gated(sd_gated));

    clkgate_fsel u_fsel (
        .sw_sel(sw_sel), .sw_code(sw_code), .strap_fs(strap_fs),
        .fs_code(fs_code), .ss_allow(ss_allow));

    assert_cs_tracks_true_R6: assert property (@(posedge clk) disable iff (rst)
        cpu_cs == cpu_t)
        else $error("chipset copy differs from true CPU clock");

    assert_z_implies_low_R2: assert property (@(posedge clk) disable iff (rst)
        !cpu_c_oe |-> (!cpu_t && !cpu_c))
        else $error("CPU clock active while complement released");

    assert_hw_top_bit_R7: assert property (@(posedge clk) disable iff (rst)
        !sw_sel |-> (fs_code[CODE_W-1] && fs_code[STRAP_W-1:0] == strap_fs))
        else $error("hardware code mismatch");

    assert_ss_range_R8: assert property (@(posedge clk) disable iff (rst)
        ss_allow |-> (sw_sel ? (sw_code[CODE_W-1 -: 3] == 3'b111)
                             : (strap_fs[STRAP_W-1 -: 2] == 2'b11)))
        else $error("spread allowed for a non-spread code");
endmodule

// File: tb/tb_clk_gate_ctrl.sv
`timescale 1ns/1ps
module tb_clk_gate_ctrl;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, pwrdn_n, stop_pin_n, mode_strap, sw_sel, en_usb, en_sio, sio_sel48;
    logic [3:0] strap_fs;
    logic [4:0] sw_code;
    logic [5:0] en_pci;
    logic [1:0] en_ref;
    logic cpu_raw, pci_raw, ref_raw, usb_raw, sio24_raw, sdram_in;
    logic cpu_t, cpu_c, cpu_c_oe, cpu_cs, ref0_oe, usb_out, sio_out, ss_allow;
    logic [5:0] pci_out;
    logic [1:0] ref_out;
    logic [12:0] sdram_out;
    logic [4:0] fs_code;

    clk_gate_ctrl dut (
        .clk(clk), .rst(rst), .pwrdn_n(pwrdn_n), .stop_pin_n(stop_pin_n),
        .mode_strap(mode_strap), .strap_fs(strap_fs), .sw_sel(sw_sel), .sw_code(sw_code),
        .en_pci(en_pci), .en_ref(en_ref), .en_usb(en_usb), .en_sio(en_sio),
        .sio_sel48(sio_sel48), .cpu_raw(cpu_raw), .pci_raw(pci_raw), .ref_raw(ref_raw),
        .usb_raw(usb_raw), .sio24_raw(sio24_raw), .sdram_in(sdram_in),
        .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_c_oe(cpu_c_oe), .cpu_cs(cpu_cs),
        .pci_out(pci_out), .ref_out(ref_out), .ref0_oe(ref0_oe), .usb_out(usb_out),
        .sio_out(sio_out), .sdram_out(sdram_out), .fs_code(fs_code), .ss_allow(ss_allow));

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // Behavioural reference state
    bit pd_hist[$];
    bit st_hist[$];
    bit m_cpu, m_usb, m_sio, m_sd;
    bit [5:0] m_pci;
    bit [1:0] m_ref;
    bit prev_cpu_t, prev_cpu_raw;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            pd_hist = '{0, 0};
            st_hist = '{1, 1};
            m_cpu = 0; m_usb = 0; m_sio = 0; m_sd = 0; m_pci = '0; m_ref = '0;
        end else begin
            bit pd_ok, run_cpu;
            pd_ok   = pd_hist[0];
            run_cpu = pd_ok && (mode_strap || st_hist[0]);
            if (!cpu_raw) m_cpu = run_cpu;
            if (!pci_raw) m_pci = pd_ok ? en_pci : 6'b0;
            if (!ref_raw) begin
                m_ref[0] = pd_ok && en_ref[0] && mode_strap;
                m_ref[1] = pd_ok && en_ref[1];
            end
            if (!usb_raw) m_usb = pd_ok && en_usb;
            if (!(sio_sel48 ? usb_raw : sio24_raw)) m_sio = pd_ok && en_sio;
            if (!sdram_in) m_sd = pd_ok;
            void'(pd_hist.pop_front());
            void'(st_hist.pop_front());
            pd_hist.push_back(pwrdn_n);
            st_hist.push_back(stop_pin_n);
        end
    end

    task automatic compare();
        bit [4:0] ecode;
        bit sraw;
        int act, exp;
        act = {cpu_t, cpu_c, cpu_c_oe};
        exp = {cpu_raw & m_cpu, ~cpu_raw & m_cpu, m_cpu};
        chk(act == exp, "R2/R10 cpu group", act, exp);
        chk(cpu_cs == cpu_t, "R6 chipset copy", cpu_cs, cpu_t);
        chk(pci_out == ({6{pci_raw}} & m_pci), "R4 pci", pci_out, {6{pci_raw}} & m_pci);
        act = {ref0_oe, ref_out};
        exp = {mode_strap, ref_raw & m_ref[1], ref_raw & m_ref[0]};
        chk(act == exp, "R3 ref", act, exp);
        chk(usb_out == (usb_raw & m_usb), "R4 usb", usb_out, usb_raw & m_usb);
        sraw = sio_sel48 ? usb_raw : sio24_raw;
        chk(sio_out == (sraw & m_sio), "R11 sio", sio_out, sraw & m_sio);
        chk(sdram_out == {13{sdram_in & m_sd}}, "R5 sdram", sdram_out, {13{sdram_in & m_sd}});
        ecode = sw_sel ? sw_code : {1'b1, strap_fs};
        chk(fs_code == ecode, "R7 code", fs_code, ecode);
        chk(ss_allow == (ecode >= 5'd28), "R8 spread", ss_allow, ecode >= 5'd28);
        if (!rst) begin
            chk(!(cpu_t && !prev_cpu_t && prev_cpu_raw), "R9 start", cpu_t, 0);
            chk(!(!cpu_t && prev_cpu_t && cpu_raw && prev_cpu_raw), "R9 cut", cpu_t, 1);
        end
        prev_cpu_t   = cpu_t;
        prev_cpu_raw = cpu_raw;
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            compare();
            cyc++;
            cpu_raw   = cyc[1];
            pci_raw   = cyc[2];
            ref_raw   = cyc[1] ^ cyc[3];
            usb_raw   = cyc[0];
            sio24_raw = cyc[1];
            sdram_in  = cyc[2] ^ cyc[0];
        end
    endtask

    initial begin
        rst = 1; pwrdn_n = 1; stop_pin_n = 1; mode_strap = 1; sw_sel = 0;
        strap_fs = 4'hF; sw_code = 5'd0; en_pci = '1; en_ref = '1; en_usb = 1;
        en_sio = 1; sio_sel48 = 0; cpu_raw = 0; pci_raw = 0; ref_raw = 0;
        usb_raw = 0; sio24_raw = 0; sdram_in = 0; prev_cpu_t = 0; prev_cpu_raw = 0;
        step(4);
        chk({cpu_t, cpu_c_oe, pci_out, ref_out, sdram_out} == 0, "R1 reset state",
            {cpu_t, cpu_c_oe, pci_out, ref_out, sdram_out}, 0);
        rst = 0;
        step(40);
        // CPU stop in mode 0
        mode_strap = 0; stop_pin_n = 0;
        step(30);
        chk({cpu_t, cpu_cs, cpu_c_oe} == 0, "R2 stopped", {cpu_t, cpu_cs, cpu_c_oe}, 0);
        chk(ref0_oe == 0 && ref_out[0] == 0, "R3 pin as input", {ref0_oe, ref_out[0]}, 0);
        stop_pin_n = 1;
        step(30);
        // Stop ignored in mode 1
        mode_strap = 1; stop_pin_n = 0;
        step(30);
        chk(cpu_c_oe == 1, "R3 stop ignored", cpu_c_oe, 1);
        stop_pin_n = 1;
        // Enable patterns
        en_pci = 6'b101101; en_ref = 2'b10; en_usb = 0; en_sio = 1; sio_sel48 = 1;
        step(30);
        en_pci = 6'b010010; en_ref = 2'b01; en_usb = 1; en_sio = 0; sio_sel48 = 0;
        step(30);
        en_pci = '1; en_ref = '1; en_sio = 1;
        // Power-down with stop also requested: priority
        mode_strap = 0; stop_pin_n = 0; pwrdn_n = 0;
        step(30);
        chk({cpu_t, cpu_c, cpu_c_oe, pci_out, ref_out, usb_out, sio_out, sdram_out} == 0,
            "R1 power-down", {cpu_c_oe, pci_out, sdram_out}, 0);
        stop_pin_n = 1;
        step(20);
        chk({cpu_c_oe, pci_out, usb_out, sdram_out} == 0, "R10 pd over stop",
            {cpu_c_oe, pci_out, usb_out, sdram_out}, 0);
        pwrdn_n = 1;
        step(30);
        // Frequency code sweeps
        mode_strap = 1;
        for (int s = 0; s < 16; s++) begin
            strap_fs = 4'(s);
            step(1);
        end
        sw_sel = 1;
        for (int c = 0; c < 32; c++) begin
            sw_code = 5'(c);
            step(1);
        end
        step(10);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule